// File: doc/BRIEF.md
# Dual-Width Flag-Setting Integer ALU

A purely combinational 64-bit integer arithmetic and logic unit for the execute stage of a RISC pipeline. It takes a first register operand and a second operand. The second operand is either a register value or a 13-bit immediate that is sign-extended to 64 bits. It returns a 64-bit result and two sets of condition flags, each ordered {N, Z, V, C} from bit 3 down to bit 0. One set is computed over the low word (bits 31:0). The other is computed over the full doubleword (bits 63:0).

An operation class chooses among the following: add, subtract, logic, tagged add, tagged subtract, shift and upper-immediate load. A modifier field refines the class: carry-in use, the logic function and second-operand inversion, whether a tagged operation traps, and the shift kind and width. A set-flags input controls whether the flag outputs are meaningful for the enclosing pipeline. The carry flag of the low word is fed back by the surrounding datapath on `carry_in`.

The block holds no state and has no clock. Each output follows its inputs within the same cycle, so no handshake applies at its edges. The surrounding pipeline register stages the operands and captures the result.

Top module: `alu_dualflag`

## Requirements
- R1: With `use_imm`=1 the second operand is `imm[12:0]` sign-extended to 64 bits; with `use_imm`=0 it is `rs2`.
- R2: Class 0 (add) gives rs1+op2 and class 1 (subtract) gives rs1+~op2+1. C is the adder carry out of bit 31 (icc) and of bit 63 (xcc). V is set when the two adder inputs share a sign bit that differs from the result's, judged at bit 31 and at bit 63.
- R3: When `op_mod[0]`=1, add adds `carry_in` and subtract gives rs1−op2−`carry_in` (adder carry-in = NOT `carry_in`). Flags follow R2.
- R4: When flags are written, N copies bit 31 (icc) or bit 63 (xcc), and Z is set when bits 31:0 (icc) or bits 63:0 (xcc) are all zero.
- R5: Class 2 (logic) uses `op_mod[1:0]`: 0 = AND, 1 = OR, 2 = XOR, 3 = AND. `op_mod[2]`=1 inverts the second operand, giving ANDN, ORN and XNOR. Logic operations clear V and C in both flag sets.
- R6: Class 3 (tagged add) and class 4 (tagged subtract) compute like add and subtract. The icc V flag is also set when bits 1:0 of rs1 or of op2 are non-zero. The xcc flags follow R2.
- R7: `tag_trap` is 1 only for a tagged class with `op_mod[0]`=1 whose low-word overflow condition of R6 holds. It does not depend on `set_flags`.
- R8: Class 5 (shift) uses `op_mod[1:0]`: 0 or 3 = left, 1 = right logical, 2 = right arithmetic. The count is taken from op2's low 5 bits when `op_mod[2]`=0 and from its low 6 bits when `op_mod[2]`=1. The narrow left shift shifts all 64 bits. The narrow right shifts act on bits 31:0 only: the logical form zero-extends the result and the arithmetic form sign-extends it from bit 31. The wide forms shift all 64 bits.
- R9: Class 6 (upper) gives `imm[21:0]` placed at bits 31:10, with bits 63:32 and 9:0 cleared.
- R10: `flags_we` = `set_flags` AND class in 0..4. When `flags_we`=0 both `icc` and `xcc` read 0. Class 7 gives result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 3 | Operation class (0 add, 1 sub, 2 logic, 3 tagged add, 4 tagged sub, 5 shift, 6 upper, 7 none) |
| op_mod | input | 3 | Class modifier field |
| use_imm | input | 1 | Select immediate as second operand |
| set_flags | input | 1 | Request flag update |
| carry_in | input | 1 | Current low-word carry flag |
| rs1 | input | 64 | First register operand |
| rs2 | input | 64 | Second register operand |
| imm | input | 22 | Immediate field (13-bit signed in bits 12:0, 22-bit upper value) |
| result | output | 64 | Operation result |
| icc | output | 4 | Low-word flags {N,Z,V,C} |
| xcc | output | 4 | Doubleword flags {N,Z,V,C} |
| flags_we | output | 1 | Flag outputs are valid for writing |
| tag_trap | output | 1 | Tagged-overflow trap request |

## Verification
The embedded checks are evaluated whenever an input changes. They cover the following: the split low/high adder always matches a single 65-bit sum; logic operations never report V or C; Z agrees with the result at both widths; disabled flags read zero; a trap appears only for the trapping tagged variant; the upper bits of a narrow logical right shift are clear; and the upper-immediate result has its low ten bits clear. Exact result values, the signed-overflow corners at bit 31 versus bit 63, borrow handling with carry-in, immediate sign extension and the shift-count truncation can only be shown by the bench's vectors with known answers.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    CLS_ADD   = 3'd0,
    CLS_SUB   = 3'd1,
    CLS_LOGIC = 3'd2,
    CLS_TADD  = 3'd3,
    CLS_TSUB  = 3'd4,
    CLS_SHIFT = 3'd5,
    CLS_UPPER = 3'd6,
    CLS_NONE  = 3'd7
  } alu_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            cin,
  output logic [XLEN-1:0] sum,
  output logic            c_lo,
  output logic            c_hi,
  output logic            v_lo,
  output logic            v_hi
);
  localparam int HALF = XLEN / 2;

  logic [HALF:0] lo_sum;
  logic [HALF:0] hi_sum;

  always_comb begin
    lo_sum = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
    hi_sum = {1'b0, a[XLEN-1:HALF]} + {1'b0, b[XLEN-1:HALF]} + {{HALF{1'b0}}, lo_sum[HALF]};
    sum    = {hi_sum[HALF-1:0], lo_sum[HALF-1:0]};
    c_lo   = lo_sum[HALF];
    c_hi   = hi_sum[HALF];
    v_lo   = (a[HALF-1] == b[HALF-1]) && (sum[HALF-1] != a[HALF-1]);
    v_hi   = (a[XLEN-1] == b[XLEN-1]) && (sum[XLEN-1] != a[XLEN-1]);
  end

  // R2: split carry chain equals one full-width addition
  always_comb begin
    p_split_sum_r2: assert ({c_hi, sum} == ({1'b0, a} + {1'b0, b} + {{XLEN{1'b0}}, cin}))
      else $error("split adder mismatch");
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [1:0]      func,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (func)
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = a & b;
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]         a,
  input  logic [$clog2(XLEN)-1:0] cnt_raw,
  input  logic [1:0]              kind,
  input  logic                    wide,
  output logic [XLEN-1:0]         y
);
  localparam int HALF  = XLEN / 2;
  localparam int CW    = $clog2(XLEN);
  localparam int CW_LO = $clog2(HALF);

  logic [CW-1:0]   cnt;
  logic [HALF-1:0] lo_srl;
  logic [HALF-1:0] lo_sra;

  always_comb begin
    cnt    = wide ? cnt_raw : {1'b0, cnt_raw[CW_LO-1:0]};
    lo_srl = a[HALF-1:0] >> cnt[CW_LO-1:0];
    lo_sra = HALF'($signed(a[HALF-1:0]) >>> cnt[CW_LO-1:0]);
    unique case (kind)
      2'd1:    y = wide ? (a >> cnt) : {{HALF{1'b0}}, lo_srl};
      2'd2:    y = wide ? XLEN'($signed(a) >>> cnt) : {{HALF{lo_sra[HALF-1]}}, lo_sra};
      default: y = a << cnt;
    endcase
  end

  // R8: narrow logical right shift leaves the upper word clear
  always_comb begin
    p_srl_narrow_upper_r8: assert (!(kind == 2'd1 && !wide) || y[XLEN-1:HALF] == '0)
      else $error("narrow logical shift upper word not clear");
  end

endmodule

// File: rtl/alu_dualflag.sv
module alu_dualflag
  import alu_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int IMM_W     = 13,
  parameter int UPPER_W   = 22,
  parameter int UPPER_LSB = 10
) (
  input  logic [2:0]               op_class,
  input  logic [2:0]               op_mod,
  input  logic                     use_imm,
  input  logic                     set_flags,
  input  logic                     carry_in,
  input  logic [XLEN-1:0]          rs1,
  input  logic [XLEN-1:0]          rs2,
  input  logic [UPPER_W-1:0]       imm,
  output logic [XLEN-1:0]          result,
  output logic [3:0]               icc,
  output logic [3:0]               xcc,
  output logic                     flags_we,
  output logic                     tag_trap
);
  localparam int HALF   = XLEN / 2;
  localparam int CW     = $clog2(XLEN);
  localparam int UP_TOP = UPPER_LSB + UPPER_W;

  alu_class_e cls;
  logic [XLEN-1:0] op2;
  logic [XLEN-1:0] op2_eff;
  logic            is_arith;
  logic            is_sub;
  logic            is_tag;
  logic            add_cin;
  logic            tag_bad;
  logic            tag_ovf;

  logic [XLEN-1:0] sum;
  logic            c_lo, c_hi, v_lo, v_hi;
  logic [XLEN-1:0] logic_y;
  logic [XLEN-1:0] shift_y;
  logic [XLEN-1:0] upper_y;
  cc_t             lo_cc, hi_cc;

  always_comb begin
    cls      = alu_class_e'(op_class);
    op2      = use_imm ? {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm[IMM_W-1:0]} : rs2;
    is_sub   = (cls == CLS_SUB) || (cls == CLS_TSUB);
    is_tag   = (cls == CLS_TADD) || (cls == CLS_TSUB);
    is_arith = (cls == CLS_ADD) || is_sub || is_tag;
    op2_eff  = (is_sub || (cls == CLS_LOGIC && op_mod[2])) ? ~op2 : op2;
    unique case (cls)
      CLS_ADD: add_cin = op_mod[0] & carry_in;
      CLS_SUB: add_cin = op_mod[0] ? ~carry_in : 1'b1;
      CLS_TSUB: add_cin = 1'b1;
      default: add_cin = 1'b0;
    endcase
    upper_y = '0;
    upper_y[UP_TOP-1:UPPER_LSB] = imm;
  end

  alu_adder #(.XLEN(XLEN)) u_adder (
    .a(rs1), .b(op2_eff), .cin(add_cin),
    .sum(sum), .c_lo(c_lo), .c_hi(c_hi), .v_lo(v_lo), .v_hi(v_hi)
  );

  alu_logic #(.XLEN(XLEN)) u_logic (
    .a(rs1), .b(op2_eff), .func(op_mod[1:0]), .y(logic_y)
  );

  alu_shifter #(.XLEN(XLEN)) u_shift (
    .a(rs1), .cnt_raw(op2[CW-1:0]), .kind(op_mod[1:0]), .wide(op_mod[2]), .y(shift_y)
  );

  always_comb begin
    unique case (cls)
      CLS_ADD, CLS_SUB, CLS_TADD, CLS_TSUB: result = sum;
      CLS_LOGIC: result = logic_y;
      CLS_SHIFT: result = shift_y;
      CLS_UPPER: result = upper_y;
      default:   result = '0;
    endcase
  end

  always_comb begin
    tag_bad  = (rs1[1:0] != 2'b00) || (op2[1:0] != 2'b00);
    tag_ovf  = is_tag && (tag_bad || v_lo);
    tag_trap = tag_ovf && op_mod[0];
    flags_we = set_flags && (is_arith || cls == CLS_LOGIC);

    lo_cc.n = result[HALF-1];
    lo_cc.z = (result[HALF-1:0] == '0);
    lo_cc.v = is_tag ? tag_ovf : (is_arith && v_lo);
    lo_cc.c = is_arith && c_lo;
    hi_cc.n = result[XLEN-1];
    hi_cc.z = (result == '0);
    hi_cc.v = is_arith && v_hi;
    hi_cc.c = is_arith && c_hi;

    icc = flags_we ? lo_cc : 4'b0000;
    xcc = flags_we ? hi_cc : 4'b0000;
  end

  // Port-level consistency checks
  always_comb begin
    p_logic_vc_clear_r5: assert (!(flags_we && cls == CLS_LOGIC) || (icc[1:0] == 2'b00 && xcc[1:0] == 2'b00))
      else $error("logic op reported V or C");
    p_zero_flags_r4: assert (!flags_we || (icc[2] == (result[HALF-1:0] == '0) && xcc[2] == (result == '0)))
      else $error("Z flag disagrees with result");
    p_flags_gated_r10: assert (flags_we || (icc == 4'b0000 && xcc == 4'b0000))
      else $error("flags visible while not written");
    p_trap_source_r7: assert (!tag_trap || (is_tag && op_mod[0]))
      else $error("trap from non-trapping op");
    p_upper_low_clear_r9: assert (cls != CLS_UPPER || (result[UPPER_LSB-1:0] == '0 && result[XLEN-1:UP_TOP] == '0))
      else $error("upper immediate spill");
  end

endmodule

// File: tb/test_alu_dualflag.sv
module test_alu_dualflag;

  typedef struct packed {
    logic [2:0]  cls;
    logic [2:0]  mod;
    logic        ui;
    logic        sf;
    logic        cin;
    logic [63:0] a;
    logic [63:0] b;
    logic [21:0] im;
    logic [63:0] res;
    logic [3:0]  ic;
    logic [3:0]  xc;
    logic        we;
    logic        tr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    // R2 add, low-word signed overflow only
    '{3'd0,3'd0,1'b0,1'b1,1'b0,64'h0000_0000_7FFF_FFFF,64'h1,22'h0,64'h0000_0000_8000_0000,4'hA,4'h0,1'b1,1'b0,8'd2},
    // R2 add, doubleword overflow, low-word carry
    '{3'd0,3'd0,1'b0,1'b1,1'b0,64'h7FFF_FFFF_FFFF_FFFF,64'h1,22'h0,64'h8000_0000_0000_0000,4'h5,4'hA,1'b1,1'b0,8'd2},
    // R1 positive immediate wraps to zero
    '{3'd0,3'd0,1'b1,1'b1,1'b0,64'hFFFF_FFFF_FFFF_FFFF,64'h0,22'h0001,64'h0,4'h5,4'h5,1'b1,1'b0,8'd1},
    // R1 negative immediate sign-extends
    '{3'd0,3'd0,1'b1,1'b1,1'b0,64'h10,64'hDEAD,22'h1FFF,64'hF,4'h1,4'h1,1'b1,1'b0,8'd1},
    // R2 subtract to negative
    '{3'd1,3'd0,1'b0,1'b1,1'b0,64'h5,64'h7,22'h0,64'hFFFF_FFFF_FFFF_FFFE,4'h8,4'h8,1'b1,1'b0,8'd2},
    // R4 subtract equal -> zero
    '{3'd1,3'd0,1'b0,1'b1,1'b0,64'h1234,64'h1234,22'h0,64'h0,4'h5,4'h5,1'b1,1'b0,8'd4},
    // R3 add with carry
    '{3'd0,3'd1,1'b0,1'b1,1'b1,64'h1,64'h2,22'h0,64'h4,4'h0,4'h0,1'b1,1'b0,8'd3},
    // R3 subtract with carry
    '{3'd1,3'd1,1'b0,1'b1,1'b1,64'hA,64'h3,22'h0,64'h6,4'h1,4'h1,1'b1,1'b0,8'd3},
    // R3 carry-in ignored without modifier
    '{3'd0,3'd0,1'b0,1'b1,1'b1,64'h1,64'h2,22'h0,64'h3,4'h0,4'h0,1'b1,1'b0,8'd3},
    // R5 ANDN
    '{3'd2,3'd4,1'b0,1'b1,1'b0,64'hF0F0,64'h00FF,22'h0,64'hF000,4'h0,4'h0,1'b1,1'b0,8'd5},
    // R5 XNOR
    '{3'd2,3'd6,1'b0,1'b1,1'b0,64'h5,64'h5,22'h0,64'hFFFF_FFFF_FFFF_FFFF,4'h8,4'h8,1'b1,1'b0,8'd5},
    // R5 ORN
    '{3'd2,3'd5,1'b0,1'b1,1'b0,64'h0,64'hFFFF_FFFF_FFFF_FFF0,22'h0,64'hF,4'h0,4'h0,1'b1,1'b0,8'd5},
    // R10 OR without flag request
    '{3'd2,3'd1,1'b0,1'b0,1'b0,64'h8000_0000_0000_0000,64'h0,22'h0,64'h8000_0000_0000_0000,4'h0,4'h0,1'b0,1'b0,8'd10},
    // R7 tagged add aligned, trapping variant, no trap
    '{3'd3,3'd1,1'b0,1'b1,1'b0,64'h4,64'h8,22'h0,64'hC,4'h0,4'h0,1'b1,1'b0,8'd7},
    // R6 tagged add misaligned, non-trapping
    '{3'd3,3'd0,1'b0,1'b1,1'b0,64'h5,64'h8,22'h0,64'hD,4'h2,4'h0,1'b1,1'b0,8'd6},
    // R7 tagged add misaligned, trapping
    '{3'd3,3'd1,1'b0,1'b1,1'b0,64'h5,64'h8,22'h0,64'hD,4'h2,4'h0,1'b1,1'b1,8'd7},
    // R6 tagged subtract, signed low-word overflow
    '{3'd4,3'd0,1'b0,1'b1,1'b0,64'h8000_0000,64'h4,22'h0,64'h7FFF_FFFC,4'h3,4'h1,1'b1,1'b0,8'd6},
    // R8 narrow left, count truncated to 5 bits
    '{3'd5,3'd0,1'b1,1'b1,1'b0,64'h1,64'h0,22'h21,64'h2,4'h0,4'h0,1'b0,1'b0,8'd8},
    // R8 wide left, 6-bit count
    '{3'd5,3'd4,1'b1,1'b0,1'b0,64'h1,64'h0,22'h21,64'h2_0000_0000,4'h0,4'h0,1'b0,1'b0,8'd8},
    // R8 narrow logical right
    '{3'd5,3'd1,1'b0,1'b0,1'b0,64'hFFFF_FFFF_8000_0000,64'h4,22'h0,64'h0800_0000,4'h0,4'h0,1'b0,1'b0,8'd8},
    // R8 narrow arithmetic right
    '{3'd5,3'd2,1'b0,1'b0,1'b0,64'hFFFF_FFFF_8000_0000,64'h4,22'h0,64'hFFFF_FFFF_F800_0000,4'h0,4'h0,1'b0,1'b0,8'd8},
    // R8 wide arithmetic / logical right by 63
    '{3'd5,3'd6,1'b0,1'b0,1'b0,64'h8000_0000_0000_0000,64'h3F,22'h0,64'hFFFF_FFFF_FFFF_FFFF,4'h0,4'h0,1'b0,1'b0,8'd8},
    '{3'd5,3'd5,1'b0,1'b0,1'b0,64'h8000_0000_0000_0000,64'h7F,22'h0,64'h1,4'h0,4'h0,1'b0,1'b0,8'd8},
    // R9 upper immediate, flags not written
    '{3'd6,3'd0,1'b0,1'b1,1'b0,64'h1234,64'h5678,22'h3FFFFF,64'h0000_0000_FFFF_FC00,4'h0,4'h0,1'b0,1'b0,8'd9}
  };

  logic        clk = 1'b0;
  logic [2:0]  op_class = '0;
  logic [2:0]  op_mod = '0;
  logic        use_imm = 1'b0;
  logic        set_flags = 1'b0;
  logic        carry_in = 1'b0;
  logic [63:0] rs1 = '0;
  logic [63:0] rs2 = '0;
  logic [21:0] imm = '0;
  logic [63:0] result;
  logic [3:0]  icc, xcc;
  logic        flags_we, tag_trap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  alu_dualflag i_alu_dualflag (
    .op_class(op_class), .op_mod(op_mod), .use_imm(use_imm), .set_flags(set_flags),
    .carry_in(carry_in), .rs1(rs1), .rs2(rs2), .imm(imm),
    .result(result), .icc(icc), .xcc(xcc), .flags_we(flags_we), .tag_trap(tag_trap)
  );

  task automatic apply(input vec_t v);
    @(negedge clk);
    op_class = v.cls; op_mod = v.mod; use_imm = v.ui; set_flags = v.sf;
    carry_in = v.cin; rs1 = v.a; rs2 = v.b; imm = v.im;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input vec_t v, input int idx);
    checks++;
    if (result !== v.res || icc !== v.ic || xcc !== v.xc || flags_we !== v.we || tag_trap !== v.tr) begin
      fails++;
      $display("FAIL R%0d case %0d: got res=%h icc=%h xcc=%h we=%b trap=%b, exp res=%h icc=%h xcc=%h we=%b trap=%b",
               v.req, idx, result, icc, xcc, flags_we, tag_trap, v.res, v.ic, v.xc, v.we, v.tr);
    end
  endtask

  initial begin
    vec_t d;
    // R10 idle state: all-zero inputs, flags not requested
    @(posedge clk); #1;
    d = '{3'd0,3'd0,1'b0,1'b0,1'b0,64'h0,64'h0,22'h0,64'h0,4'h0,4'h0,1'b0,1'b0,8'd10};
    check(d, -1);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check(VECS[i], i);
    end

    // R7 trap fires even with flag update disabled
    d = '{3'd4,3'd1,1'b0,1'b0,1'b0,64'h6,64'h1,22'h0,64'h5,4'h0,4'h0,1'b0,1'b1,8'd7};
    apply(d); check(d, 100);
    // R10 unused class yields zero and no flags
    d = '{3'd7,3'd0,1'b0,1'b1,1'b1,64'hFFFF,64'hFFFF,22'h3FF,64'h0,4'h0,4'h0,1'b0,1'b0,8'd10};
    apply(d); check(d, 101);
    // R2 subtract crossing zero at the low word only
    d = '{3'd1,3'd0,1'b0,1'b1,1'b0,64'h1_0000_0000,64'h1,22'h0,64'h0000_0000_FFFF_FFFF,4'h8,4'h1,1'b1,1'b0,8'd2};
    apply(d); check(d, 102);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule